// File: doc/BRIEF.md
# USB Cable and Attach Status Monitor

This block watches the raw USB identification pin, the two data lines and the VBUS-valid comparator output. It brings each of them into the local clock domain and filters the data-line condition with a programmable debounce window. From the result it raises cable and connection events and stores them in sticky flags, which software reads and clears through a small register port. One interrupt output combines the flags under a per-source enable mask.

The block works in one of two roles, which software selects with a control bit: a disconnected host, or a disconnected device. In host role it reports device attach and device removal (the reset event). While a device is attached, the J-state status bit tells a full-speed device (D+ high) from a low-speed one (D- high, so the bit reads 0). In device role it never reports an attach. It reports a VBUS-valid rise when a host connects, and a line-state change when the host goes away. A change of the identification pin is reported in both roles.

Register map (address, 2 bits): 0 = STATUS (read-only), 1 = FLAGS (write 1 to clear), 2 = MASK (read/write), 3 = CTRL (read/write). STATUS bits: 0 id level, 1 SE0 (no debounced connection), 2 J-state (synchronized D+), 3 synchronized VBUS-valid. FLAGS and MASK bits: 0 id change, 1 attach, 2 reset, 3 VBUS-valid, 4 line-state change. CTRL bits: 0 pull-down enable, 1 role (0 host, 1 device).

The connection tracker is a four-state machine:
- DETACHED: line at SE0. It moves to ATT_WAIT when the line leaves SE0.
- ATT_WAIT: counting a non-SE0 line. It returns to DETACHED on SE0, and moves to ATTACHED with an attach event when the count completes.
- ATTACHED: connected. It moves to DET_WAIT on SE0.
- DET_WAIT: counting SE0. It returns to ATTACHED when the line leaves SE0, and moves to DETACHED with a detach event when the count completes.

Top module: `usb_cable_monitor`

## Requirements
- R1: After reset FLAGS, MASK and CTRL read 0, irq and pulldown_en are 0, and with id high and the lines at SE0, STATUS reads 0x03.
- R2: STATUS bit 0 follows the id input through a two-flop synchronizer, and every change of id sets FLAGS bit 0 in either role.
- R3: STATUS bit 1 reads 1 while no debounced connection exists and 0 once an attach has been debounced, in either role.
- R4: STATUS bit 2 reads the synchronized D+ level, so it reads 1 for an attached full-speed device and 0 for a low-speed one.
- R5: In host role a line held away from SE0 for DEB_CYCLES cycles sets FLAGS bit 1. A shorter excursion sets no flag.
- R6: In host role a line held at SE0 for DEB_CYCLES cycles after a connection sets FLAGS bit 2. This includes cable removal with the device still on it.
- R7: In device role no attach flag is ever set. A rise of VBUS-valid sets FLAGS bit 3, and a debounced disconnect sets FLAGS bit 4.
- R8: In host role changes of VBUS-valid set no flag.
- R9: Flags stay set until software writes 1 to their bit at address 1. Writing 0 to a bit leaves it unchanged.
- R10: irq is 1 exactly when some flag bit and the same MASK bit (address 2) are both 1.
- R11: CTRL bit 0 (address 3) drives pulldown_en, and CTRL reads back as written (bits 1:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_in | input | 1 | Raw identification pin (low when an A-type end is inserted) |
| dp_in | input | 1 | Raw D+ receiver level |
| dm_in | input | 1 | Raw D- receiver level |
| vbus_vld_in | input | 1 | Raw VBUS-valid comparator output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Masked interrupt request |
| pulldown_en | output | 1 | Pull-down resistor enable |

## Verification
The bench builds the block with DEB_CYCLES = 5, which keeps each debounce window to a handful of cycles. With that setting a two-cycle line excursion falls below the window, while a twenty-cycle hold lies well beyond it, so both the glitch case and every attach and detach path in both roles can be reached. Random identification toggles, random roles and random masks are then checked against the expected flag and irq values that the bench computes itself.

// File: rtl/usb_cable_monitor_pkg.sv
package usb_cable_monitor_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;
    localparam int NFLAG  = 5;

    localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_FLAGS  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_MASK   = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd3;

    localparam int FL_ID    = 0;
    localparam int FL_ATT   = 1;
    localparam int FL_RST   = 2;
    localparam int FL_VBUS  = 3;
    localparam int FL_LINE  = 4;

    typedef enum logic [1:0] {
        ST_DETACHED = 2'd0,
        ST_ATT_WAIT = 2'd1,
        ST_ATTACHED = 2'd2,
        ST_DET_WAIT = 2'd3
    } conn_state_t;

endpackage

// File: rtl/usb_sync_bank.sv
module usb_sync_bank #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= rst_val;
        end else begin
            stage_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/usb_conn_fsm.sv
module usb_conn_fsm
    import usb_cable_monitor_pkg::*;
#(
    parameter int DEB_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_se0,
    output logic connected,
    output logic attach_evt,
    output logic detach_evt
);
    localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    conn_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          cnt_done;

    assign cnt_done = (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DETACHED: if (!line_se0) state_d = ST_ATT_WAIT;
            ST_ATT_WAIT: begin
                if (line_se0)      state_d = ST_DETACHED;
                else if (cnt_done) state_d = ST_ATTACHED;
            end
            ST_ATTACHED: if (line_se0) state_d = ST_DET_WAIT;
            ST_DET_WAIT: begin
                if (!line_se0)     state_d = ST_ATTACHED;
                else if (cnt_done) state_d = ST_DETACHED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DETACHED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (!cnt_done)     cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        connected  = 1'b0;
        attach_evt = 1'b0;
        detach_evt = 1'b0;
        unique case (state_q)
            ST_DETACHED: connected = 1'b0;
            ST_ATT_WAIT: attach_evt = !line_se0 && cnt_done;
            ST_ATTACHED: connected = 1'b1;
            ST_DET_WAIT: begin
                connected  = 1'b1;
                detach_evt = line_se0 && cnt_done;
            end
        endcase
    end

    assert_evt_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({attach_evt, detach_evt}));
    assert_attach_nonse0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        attach_evt |-> !line_se0);
    assert_detach_se0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        detach_evt |=> !connected);
endmodule

// File: rtl/usb_cable_monitor.sv
module usb_cable_monitor
    import usb_cable_monitor_pkg::*;
#(
    parameter int DEB_CYCLES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_in,
    input  logic              dp_in,
    input  logic              dm_in,
    input  logic              vbus_vld_in,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    output logic              pulldown_en
);
    logic [3:0] raw_vec, sync_vec;
    logic       id_s, dp_s, dm_s, vbus_s;
    logic       id_d, vbus_d;
    logic       connected, attach_evt, detach_evt;
    logic       role_dev;

    logic [NFLAG-1:0] flags_q, mask_q, set_vec, clr_vec;
    logic [1:0]       ctrl_q;

    assign raw_vec = {vbus_vld_in, dm_in, dp_in, id_in};

    usb_sync_bank #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (4'b0001),
        .d_in    (raw_vec),
        .q_out   (sync_vec)
    );

    assign {vbus_s, dm_s, dp_s, id_s} = sync_vec;

    usb_conn_fsm #(.DEB_CYCLES(DEB_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_se0   (!dp_s && !dm_s),
        .connected  (connected),
        .attach_evt (attach_evt),
        .detach_evt (detach_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_d   <= 1'b1;
            vbus_d <= 1'b0;
        end else begin
            id_d   <= id_s;
            vbus_d <= vbus_s;
        end
    end

    assign role_dev = ctrl_q[1];

    always_comb begin
        set_vec          = '0;
        set_vec[FL_ID]   = id_s ^ id_d;
        set_vec[FL_ATT]  = attach_evt && !role_dev;
        set_vec[FL_RST]  = detach_evt && !role_dev;
        set_vec[FL_VBUS] = vbus_s && !vbus_d && role_dev;
        set_vec[FL_LINE] = detach_evt && role_dev;
    end

    assign clr_vec = (reg_wr && reg_addr == ADDR_FLAGS) ? reg_wdata[NFLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            mask_q  <= '0;
            ctrl_q  <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (reg_wr && reg_addr == ADDR_MASK) mask_q <= reg_wdata[NFLAG-1:0];
            if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata[3:0]       = {vbus_s, dp_s, !connected, id_s};
            ADDR_FLAGS:  reg_rdata[NFLAG-1:0] = flags_q;
            ADDR_MASK:   reg_rdata[NFLAG-1:0] = mask_q;
            ADDR_CTRL:   reg_rdata[1:0]       = ctrl_q;
        endcase
    end

    assign irq         = |(flags_q & mask_q);
    assign pulldown_en = ctrl_q[0];

    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_vec)) == $past(flags_q & ~clr_vec)));
    assert_no_attach_dev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FL_ATT]) |-> !$past(role_dev));
    assert_no_vbus_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FL_VBUS]) |-> $past(role_dev));
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

// File: tb/tb_usb_cable_monitor.sv
module tb_usb_cable_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int DEB = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_in = 1'b1, dp_in = 1'b0, dm_in = 1'b0, vbus_vld_in = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic irq, pulldown_en;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_cable_monitor #(.DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .id_in(id_in), .dp_in(dp_in), .dm_in(dm_in),
        .vbus_vld_in(vbus_vld_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .pulldown_en(pulldown_en)
    );

    function automatic logic exp_irq(input logic [4:0] fl, input logic [4:0] mk);
        return |(fl & mk);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_flags(input string req, input logic [4:0] fl);
        logic [7:0] v;
        rd(2'd1, v);
        check(req, v, {3'b0, fl});
        wr(2'd1, 8'h1F);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       cur_id;
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R1 reset state
        rd(2'd0, v); check("R1 status", v, 8'h03);
        rd(2'd1, v); check("R1 flags", v, 8'h00);
        rd(2'd2, v); check("R1 mask", v, 8'h00);
        rd(2'd3, v); check("R1 ctrl", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 pulldown", {7'b0, pulldown_en}, 8'h00);

        wr(2'd2, 8'h1F);
        // host role, A-type cable inserted: R2, R3
        id_in = 1'b0; idle(6);
        rd(2'd0, v); check("R2 R3 status id low se0", v, 8'h02);
        check("R10 irq on id flag", {7'b0, irq}, 8'h01);
        rd(2'd1, v); check("R2 id flag", v, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R9 write zero keeps flag", v, 8'h01);
        wr(2'd1, 8'h01);
        rd(2'd1, v); check("R9 w1c", v, 8'h00);
        check("R10 irq cleared", {7'b0, irq}, 8'h00);

        // glitch shorter than window: R5
        dp_in = 1'b1; idle(2); dp_in = 1'b0; idle(20);
        expect_flags("R5 glitch ignored", 5'h00);

        // low-speed attach: R3 R4 R5
        dm_in = 1'b1; idle(20);
        rd(2'd0, v); check("R3 R4 low-speed status", v, 8'h00);
        expect_flags("R5 attach flag", 5'h02);
        wr(2'd3, 8'h01);
        check("R11 pulldown on", {7'b0, pulldown_en}, 8'h01);
        rd(2'd3, v); check("R11 ctrl readback", v, 8'h01);
        // detach: R6
        dm_in = 1'b0; idle(20);
        expect_flags("R6 reset flag", 5'h04);
        rd(2'd0, v); check("R3 se0 after detach", v, 8'h02);
        wr(2'd3, 8'h00);
        check("R11 pulldown off", {7'b0, pulldown_en}, 8'h00);

        // full-speed attach: R4
        dp_in = 1'b1; idle(20);
        rd(2'd0, v); check("R4 full-speed jstate", v, 8'h04);
        expect_flags("R5 full-speed attach", 5'h02);
        vbus_vld_in = 1'b1; idle(10);
        expect_flags("R8 host ignores vbus", 5'h00);
        // cable removed with device: R6
        id_in = 1'b1; dp_in = 1'b0; vbus_vld_in = 1'b0; idle(20);
        expect_flags("R6 removal id and reset", 5'h05);
        rd(2'd0, v); check("R2 id high again", v, 8'h03);

        // device role: R7
        wr(2'd3, 8'h02);
        id_in = 1'b0; dp_in = 1'b1; idle(20);
        rd(2'd0, v); check("R7 R3 device on A cable se0 low", v, 8'h04);
        expect_flags("R7 no attach in device role", 5'h01);
        id_in = 1'b1; dp_in = 1'b0; idle(20);
        expect_flags("R7 id and line change", 5'h11);
        vbus_vld_in = 1'b1; dp_in = 1'b1; idle(20);
        rd(2'd0, v); check("R7 host connected id high", v, 8'h0D);
        expect_flags("R7 vbus flag", 5'h08);
        vbus_vld_in = 1'b0; dp_in = 1'b0; idle(20);
        expect_flags("R7 line-state flag", 5'h10);

        // random id toggles, roles and masks: R2 R10
        cur_id = 1'b1;
        void'($urandom(32'd1234));
        for (int i = 0; i < 40; i++) begin
            logic nid;
            logic [4:0] mk;
            logic [4:0] fl;
            nid = 1'($urandom);
            mk  = 5'($urandom);
            wr(2'd3, {6'b0, 1'($urandom), 1'b0});
            wr(2'd2, {3'b0, mk});
            id_in = nid; idle(6);
            fl = {4'b0, nid ^ cur_id};
            check("R10 random irq", {7'b0, irq}, {7'b0, exp_irq(fl, mk)});
            expect_flags("R2 random id change", fl);
            cur_id = nid;
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule